// File: doc/BRIEF.md
# Packet Indication Pin Controller

This block owns one multipurpose pin and decides, from a 16-bit configuration register, what that pin does. In three of its four functions the pin is an output. Receive-start events, transmit-start events, or both are stretched into a fixed-width pulse. Each pulse is either a high pulse on a pin that idles low or a low pulse on a pin that idles high. In the fourth function the pin turns into an input. Its synchronized level, read through a selectable polarity, gives or withholds the transmitter's permission to send.

The host writes the whole register in one cycle and can read it back at any time. The packet logic supplies single-cycle start strobes. The pad logic takes the pin value and output enable, and drives back the sampled pin level. Any write that alters the stored configuration ends a pulse that is still running, so the pin settles at the idle level of the new setting.

Top module: `pkt_ind_pin`

## Requirements
- R1: After reset the register reads 16'h8000, which selects combined indication. The pin output is 0, the output enable is 1 and tx_allow is 1.
- R2: A write stores bits 15:14 (function), 7:6 (transmit polarity), 5:4 (receive polarity) and 1:0 (gate polarity). All other bits read back as 0.
- R3: Function code 00 pulses on receive events only, 01 on transmit events only, and 10 on either. An event of the kind the function does not select leaves the pin unchanged.
- R4: When an event strobe is sampled high, the pin shows its active level from the next cycle for exactly PULSE_CYCLES cycles and then returns to idle.
- R5: An event during a pulse restarts the full width. In combined mode, receive and transmit events in the same cycle give one pulse of the normal width.
- R6: Polarity code 01 gives an idle-high pin with a low pulse. Codes 00, 10 and 11 give an idle-low pin with a high pulse. Function 00 uses the receive polarity; functions 01 and 10 use the transmit polarity.
- R7: With function code 11 the output enable is 0, the pin output is 0, and event strobes produce no pulse.
- R8: With function code 11, tx_allow follows pin_i through two synchronizing flops. Gate polarity 01 gives tx_allow = !pin. Codes 00, 10 and 11 give tx_allow = pin. In functions 00, 01 and 10, tx_allow is 1 whatever pin_i does.
- R9: A write that changes the stored configuration cancels any pulse in progress. From the next cycle the pin sits at the idle level of the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| rx_evt | input | 1 | Single-cycle receive-start strobe |
| tx_evt | input | 1 | Single-cycle transmit-start strobe |
| pin_i | input | 1 | Level sampled at the pin |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| tx_allow | output | 1 | Transmit permission |
| cfg_rdata | output | 16 | Register readback |

## Verification
The stretcher is driven with lone receive events, lone transmit events and simultaneous pairs in each output function. These show whether event routing follows the function code and whether a coincident pair merges into a single pulse. A second event fired partway through a pulse tells a restarting counter apart from one that ignores retriggers or adds the two widths together. Polarity codes 00, 01 and an undefined code are tried on both polarity fields, which exposes a polarity taken from the wrong field. In the gate function, pin steps are timed edge by edge to confirm the two-flop latency and the gate polarity. A write landing mid-pulse checks that the pulse is cancelled and that the pin drops straight to the new idle level.

// File: rtl/pinx_pkg.sv
package pinx_pkg;

  typedef enum logic [1:0] {
    PIN_RXIND = 2'b00,
    PIN_TXIND = 2'b01,
    PIN_BOTH  = 2'b10,
    PIN_GATE  = 2'b11
  } pin_fn_e;

  typedef struct packed {
    pin_fn_e    fn;
    logic [1:0] txpol;
    logic [1:0] rxpol;
    logic [1:0] gatepol;
  } pin_cfg_t;

  localparam logic [15:0] CFG_RESET = 16'h8000;
  localparam logic [15:0] CFG_MASK  = 16'hC0F3;

  // Only code 01 inverts; the undefined codes fall back to code 00.
  function automatic logic pol_inverted(input logic [1:0] pol);
    return (pol == 2'b01);
  endfunction

endpackage

// File: rtl/pinx_cfg_reg.sv
module pinx_cfg_reg
  import pinx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output pin_cfg_t    cfg,
  output logic [15:0] rd_data,
  output logic        cfg_change
);

  logic [15:0] reg_q;
  logic [15:0] reg_d;
  logic [15:0] masked_wr;

  always_comb begin
    masked_wr  = wr_data & CFG_MASK;
    reg_d      = reg_q;
    cfg_change = 1'b0;
    if (wr_en) begin
      reg_d      = masked_wr;
      cfg_change = (masked_wr != reg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= CFG_RESET;
    else if (wr_en) reg_q <= reg_d;
  end

  assign rd_data     = reg_q;
  assign cfg.fn      = pin_fn_e'(reg_q[15:14]);
  assign cfg.txpol   = reg_q[7:6];
  assign cfg.rxpol   = reg_q[5:4];
  assign cfg.gatepol = reg_q[1:0];

  // Unused bit positions never hold a one.
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~CFG_MASK) == 16'h0000);

endmodule

// File: rtl/pinx_pulse.sv
module pinx_pulse #(
  parameter int PULSE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic cancel,
  output logic active
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cancel) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (trig) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cancel) |=> (cnt_q == LOAD));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !active);

endmodule

// File: rtl/pinx_gate_in.sv
module pinx_gate_in
  import pinx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] pol,
  input  logic       sel,
  output logic       allow
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign allow = sel ? (sync_q[SYNC_STAGES-1] ^ pol_inverted(pol)) : 1'b1;

  // Two steady samples on the pin fix the permission two edges later.
  assert_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && pol == 2'b00 && $past(pol) == 2'b00 &&
     $past(pin_i, 2) == $past(pin_i)) |-> (allow == $past(pin_i)));

endmodule

// File: rtl/pkt_ind_pin.sv
module pkt_ind_pin
  import pinx_pkg::*;
#(
  parameter int PULSE_CYCLES = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic        rx_evt,
  input  logic        tx_evt,
  input  logic        pin_i,
  output logic        pin_o,
  output logic        pin_oe,
  output logic        tx_allow,
  output logic [15:0] cfg_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  pin_cfg_t cfg;
  logic     cfg_change;
  logic     trig;
  logic     out_inv;
  logic     pulse_active;
  logic     gate_sel;

  pinx_cfg_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .cfg        (cfg),
    .rd_data    (cfg_rdata),
    .cfg_change (cfg_change)
  );

  always_comb begin
    trig    = 1'b0;
    out_inv = pol_inverted(cfg.txpol);
    case (cfg.fn)
      PIN_RXIND: begin
        trig    = rx_evt;
        out_inv = pol_inverted(cfg.rxpol);
      end
      PIN_TXIND: trig = tx_evt;
      PIN_BOTH:  trig = rx_evt | tx_evt;
      default:   trig = 1'b0;
    endcase
  end

  pinx_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_s),
    .trig   (trig),
    .cancel (cfg_change),
    .active (pulse_active)
  );

  assign gate_sel = (cfg.fn == PIN_GATE);

  pinx_gate_in #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk   (clk),
    .rst_n (rst_s),
    .pin_i (pin_i),
    .pol   (cfg.gatepol),
    .sel   (gate_sel),
    .allow (tx_allow)
  );

  assign pin_oe = !gate_sel;
  assign pin_o  = gate_sel ? 1'b0 : (pulse_active ^ out_inv);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (gate_sel && !cfg_change) |=> !pulse_active);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_change && cfg_wdata[15:14] != 2'b11) |=> (pin_o == out_inv));

endmodule

// File: tb/sim_pkt_ind_pin.sv
`timescale 1ns/1ps
module sim_pkt_ind_pin;

  localparam int W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        rx_evt = 1'b0;
  logic        tx_evt = 1'b0;
  logic        pin_i = 1'b0;
  logic        pin_o, pin_oe, tx_allow;
  logic [15:0] cfg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_ind_pin #(.PULSE_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .tx_allow(tx_allow), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [15:0] mk(input logic [1:0] fn, input logic [1:0] txp,
                                     input logic [1:0] rxp, input logic [1:0] gp);
    return {fn, 6'b0, txp, rxp, 2'b0, gp};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fire(input logic rx, input logic tx);
    @(negedge clk); rx_evt = rx; tx_evt = tx;
    @(negedge clk); rx_evt = 1'b0; tx_evt = 1'b0;
  endtask

  // Counts consecutive sampled cycles at the given level, from now on.
  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (pin_o == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 rdata", cfg_rdata, 16'h8000);
    check("R1 pin_o", pin_o, 0);
    check("R1 pin_oe", pin_oe, 1);
    check("R1 tx_allow", tx_allow, 1);
  endtask

  task automatic t_regs;
    wr(16'hFFFF);
    check("R2 all ones", cfg_rdata, 16'hC0F3);
    wr(16'h3F0C);
    check("R2 reserved", cfg_rdata, 16'h0000);
    wr(mk(2'b10, 2'b00, 2'b00, 2'b00));
    check("R2 restore", cfg_rdata, 16'h8000);
  endtask

  task automatic t_width;
    int n;
    fire(1'b1, 1'b0);
    count_level(1'b1, n);
    check("R4 rx width combined", n, W);
    fire(1'b0, 1'b1);
    count_level(1'b1, n);
    check("R4 tx width combined", n, W);
    fire(1'b1, 1'b1);
    count_level(1'b1, n);
    check("R5 coincident single pulse", n, W);
  endtask

  task automatic t_select;
    int n;
    wr(mk(2'b00, 2'b00, 2'b01, 2'b00));
    check("R6 rx pol 01 idle high", pin_o, 1);
    fire(1'b0, 1'b1);
    count_level(1'b1, n);
    check("R3 tx ignored in rx mode", n, 100);
    fire(1'b1, 1'b0);
    count_level(1'b0, n);
    check("R3 R6 rx low pulse", n, W);
    wr(mk(2'b01, 2'b00, 2'b01, 2'b00));
    check("R6 tx pol 00 idle low", pin_o, 0);
    fire(1'b1, 1'b0);
    count_level(1'b0, n);
    check("R3 rx ignored in tx mode", n, 100);
    fire(1'b0, 1'b1);
    count_level(1'b1, n);
    check("R3 tx high pulse", n, W);
    wr(mk(2'b10, 2'b10, 2'b01, 2'b00));
    check("R6 undefined tx pol idle low", pin_o, 0);
    fire(1'b1, 1'b0);
    count_level(1'b1, n);
    check("R6 combined uses tx pol", n, W);
    wr(mk(2'b10, 2'b01, 2'b00, 2'b00));
    check("R6 combined pol 01 idle high", pin_o, 1);
    fire(1'b0, 1'b1);
    count_level(1'b0, n);
    check("R6 combined low pulse", n, W);
  endtask

  task automatic t_retrigger;
    int n;
    wr(mk(2'b10, 2'b00, 2'b00, 2'b00));
    fire(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 mid pulse", pin_o, 1);
    fire(1'b0, 1'b1);
    count_level(1'b1, n);
    check("R5 restart width", n, W);
  endtask

  task automatic t_cancel;
    fire(1'b1, 1'b0);
    @(negedge clk);
    check("R9 pulse running", pin_o, 1);
    wr(mk(2'b10, 2'b01, 2'b00, 2'b00));
    check("R9 new idle high at once", pin_o, 1);
    @(negedge clk);
    check("R9 stays idle", pin_o, 1);
    fire(1'b1, 1'b0);
    wr(mk(2'b10, 2'b00, 2'b00, 2'b00));
    check("R9 cancel to idle low", pin_o, 0);
    repeat (3) @(negedge clk);
    check("R9 no resumed pulse", pin_o, 0);
  endtask

  task automatic t_gate;
    int n;
    pin_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 output mode allow", tx_allow, 1);
    wr(mk(2'b11, 2'b00, 2'b00, 2'b00));
    check("R7 oe off", pin_oe, 0);
    check("R7 pin_o 0", pin_o, 0);
    check("R8 pin low pol 00", tx_allow, 0);
    pin_i = 1'b1;
    @(negedge clk);
    check("R8 one edge not yet", tx_allow, 0);
    @(negedge clk);
    check("R8 two edges", tx_allow, 1);
    fire(1'b1, 1'b1);
    count_level(1'b0, n);
    check("R7 events no pulse", n, 100);
    check("R7 oe still off", pin_oe, 0);
    wr(mk(2'b11, 2'b00, 2'b00, 2'b01));
    check("R8 pol 01 inverts", tx_allow, 0);
    pin_i = 1'b0;
    @(negedge clk);
    check("R8 pol 01 one edge", tx_allow, 0);
    @(negedge clk);
    check("R8 pol 01 two edges", tx_allow, 1);
    wr(mk(2'b11, 2'b00, 2'b00, 2'b11));
    check("R8 undefined pol like 00", tx_allow, 0);
    wr(mk(2'b01, 2'b00, 2'b00, 2'b11));
    check("R8 back to output allow", tx_allow, 1);
    check("R7 oe back on", pin_oe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_width;
    t_select;
    t_retrigger;
    t_cancel;
    t_gate;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule